// File: doc/BRIEF.md
# Three-Level Prioritized Interrupt Controller

This block gathers single-cycle event pulses from a set of peripheral sources and a small group of fault sources. Every pulse is captured in a pending register, where it stays until the CPU takes the interrupt or software clears it. Each peripheral source carries a 2-bit priority code that either switches it off or places it in one of three tiers. The fault sources are fixed in the top tier. The controller picks one winner among the eligible pending requests and presents it to the CPU as a registered request flag and a source index. The CPU then takes the request with an acknowledge strobe.

The controller also holds the global interrupt enable. Reset, a disable strobe, a trap strobe, an accepted acknowledge or a register write of 0 clears it. A return-from-interrupt strobe or a register write of 1 sets it. Software reaches the enable, the pending bits and the priority codes through a single-cycle synchronous register port. Read data is registered.

Source index space: indices 0 to NUM_TRAP-1 are the fault sources. Index NUM_TRAP+m is peripheral source m. With the defaults (24 peripheral sources, 4 fault sources) the indices run from 0 to 27.

Top module: `irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_pulse[i]` sets pending bit i at that clock edge, and the bit stays set until it is cleared. The request outputs are registered and already reflect the new pending state in the cycle after the pulse edge.
- R2: A pending, eligible request in a higher tier (3 above 2 above 1) always wins over any request in a lower tier, whatever the source indices.
- R3: Within one tier, the lowest source index wins.
- R4: Fault sources (indices below NUM_TRAP) have no programmable priority and always belong to tier 3. They are presented even when the global enable is clear. Peripheral sources are presented only while the global enable is set.
- R5: The priority code of peripheral source m sits in bits [2j+1:2j] of priority word w, where m = 16w + j. Code 00 disables the source. Codes 01, 10 and 11 select tiers 1, 2 and 3.
- R6: `cpu_ack` while `irq_req` is high clears the pending bit of the presented index and clears the global enable at that edge. `cpu_ack` while `irq_req` is low is ignored.
- R7: A write to the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged. A source pulse in the same cycle as a clearing write, or as an acknowledge of that same source, wins, so the bit stays set.
- R8: A write to the control register with bit 0 = 0, `cpu_di` or `cpu_trap` clears the global enable. A write with bit 0 = 1 or `cpu_iret` sets it. When a clearing event and a setting event fall in the same cycle, the clear wins. Reset leaves the enable clear.
- R9: Register map: address 0 is control (bit 0 = global enable, other bits read 0). Address 1 is pending (bit i = source i). Addresses 2 and up are the priority words. `reg_rdata` returns the addressed register one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | NUM_TRAP+NUM_SRC | One-cycle request pulses, fault sources in the low bits |
| cpu_ack | input | 1 | CPU takes the presented request |
| cpu_iret | input | 1 | Return-from-interrupt strobe |
| cpu_di | input | 1 | Disable-interrupt strobe |
| cpu_trap | input | 1 | Trap instruction strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Request presented to the CPU |
| irq_id | output | $clog2(NUM_TRAP+NUM_SRC) | Index of the presented source |

## Verification
Two pairs of events can land in the same cycle. In the first, a new source pulse arrives together with a clear of its pending bit. In the second, a setting event and a clearing event hit the global enable together. The bench forces each race by driving both events in one cycle: a pulse with a zero write to the pending register, a pulse with an acknowledge of that same source, and a return-from-interrupt strobe with a disable strobe. It then reads the pending and control registers back through the port. The result counts as correct only if the pulse survived and the enable ended up clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    TIER_OFF = 2'b00,
    TIER_1   = 2'b01,
    TIER_2   = 2'b10,
    TIER_3   = 2'b11
  } tier_e;

  localparam int unsigned REG_CTRL      = 0;
  localparam int unsigned REG_PEND      = 1;
  localparam int unsigned REG_PRIO_BASE = 2;
  localparam int unsigned CODES_PER_WORD = 16;
  localparam int unsigned DATA_W        = 32;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned N = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pulse,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] ack_mask,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] pend_nxt
);
  logic [N-1:0] wr_clear;

  // A written 0 clears, a written 1 keeps; a pulse always wins.
  assign wr_clear = wr_en ? ~wr_data : '0;
  assign pend_nxt = (pend_q & ~wr_clear & ~ack_mask) | pulse;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned NWORDS = (NUM_SRC + CODES_PER_WORD - 1) / CODES_PER_WORD,
  localparam int unsigned PADW   = NWORDS * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [2*NUM_SRC-1:0] codes,
  output logic [PADW-1:0]      words
);
  logic [2*NUM_SRC-1:0] code_q;

  for (genvar m = 0; m < NUM_SRC; m++) begin : g_code
    localparam int unsigned W = m / CODES_PER_WORD;
    localparam int unsigned F = m % CODES_PER_WORD;
    always_ff @(posedge clk) begin
      if (rst)
        code_q[2*m +: 2] <= TIER_OFF;
      else if (wr_en && wr_addr == ADDR_W'(REG_PRIO_BASE + W))
        code_q[2*m +: 2] <= wr_data[2*F +: 2];
    end
  end

  assign codes = code_q;
  assign words = PADW'(code_q);
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int unsigned N = 28,
  localparam int unsigned IDW = $clog2(N)
) (
  input  logic [N-1:0]   elig,
  input  logic [2*N-1:0] tiers,
  output logic           any,
  output logic [IDW-1:0] id
);
  logic [N-1:0] v1, v2, v3, sel;

  for (genvar i = 0; i < N; i++) begin : g_split
    assign v3[i] = elig[i] && (tiers[2*i +: 2] == TIER_3);
    assign v2[i] = elig[i] && (tiers[2*i +: 2] == TIER_2);
    assign v1[i] = elig[i] && (tiers[2*i +: 2] == TIER_1);
  end

  assign sel = (|v3) ? v3 : ((|v2) ? v2 : v1);
  assign any = |sel;

  always_comb begin
    id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) id = IDW'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 24,
  parameter int unsigned NUM_TRAP = 4,
  parameter int unsigned ADDR_W   = 4,
  localparam int unsigned N       = NUM_SRC + NUM_TRAP,
  localparam int unsigned IDW     = $clog2(N),
  localparam int unsigned NWORDS  = (NUM_SRC + CODES_PER_WORD - 1) / CODES_PER_WORD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      src_pulse,
  input  logic              cpu_ack,
  input  logic              cpu_iret,
  input  logic              cpu_di,
  input  logic              cpu_trap,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_req,
  output logic [IDW-1:0]    irq_id
);
  logic                  gie_q, gie_nxt, gie_clr, gie_set;
  logic                  ack_ok, ctrl_wr, pend_wr;
  logic [N-1:0]          ack_mask, pend_q, pend_nxt, elig;
  logic [2*NUM_SRC-1:0]  codes;
  logic [NWORDS*32-1:0]  words;
  logic [2*N-1:0]        tiers;
  logic [N-1:0]          trap_mask, code_on;
  logic                  pick_any;
  logic [IDW-1:0]        pick_id;
  logic [31:0]           rd_mux;

  assign ack_ok  = cpu_ack && irq_req;
  assign ctrl_wr = reg_we && reg_addr == ADDR_W'(REG_CTRL);
  assign pend_wr = reg_we && reg_addr == ADDR_W'(REG_PEND);

  // Global enable: any clearing event beats any setting event.
  assign gie_clr = cpu_di || cpu_trap || ack_ok || (ctrl_wr && !reg_wdata[0]);
  assign gie_set = cpu_iret || (ctrl_wr && reg_wdata[0]);
  assign gie_nxt = gie_clr ? 1'b0 : (gie_set ? 1'b1 : gie_q);

  always_ff @(posedge clk) begin
    if (rst) gie_q <= 1'b0;
    else     gie_q <= gie_nxt;
  end

  assign ack_mask = ack_ok ? (N'(1) << irq_id) : '0;

  irq_pend_reg #(.N(N)) u_pend (
    .clk(clk), .rst(rst), .pulse(src_pulse), .wr_en(pend_wr),
    .wr_data(reg_wdata[N-1:0]), .ack_mask(ack_mask),
    .pend_q(pend_q), .pend_nxt(pend_nxt)
  );

  irq_prio_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_prio (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .codes(codes), .words(words)
  );

  // Fault sources sit in the low indices and are pinned to tier 3.
  assign tiers = {codes, {NUM_TRAP{TIER_3}}};

  for (genvar i = 0; i < N; i++) begin : g_elig
    if (i < NUM_TRAP) begin : g_trap
      assign trap_mask[i] = 1'b1;
      assign code_on[i]   = 1'b0;
    end else begin : g_src
      assign trap_mask[i] = 1'b0;
      assign code_on[i]   = |codes[2*(i-NUM_TRAP) +: 2];
    end
  end

  assign elig = pend_nxt & (trap_mask | (gie_nxt ? code_on : '0));

  irq_pick #(.N(N)) u_pick (
    .elig(elig), .tiers(tiers), .any(pick_any), .id(pick_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_id  <= '0;
    end else begin
      irq_req <= pick_any;
      irq_id  <= pick_id;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(REG_CTRL))
      rd_mux = {31'd0, gie_q};
    else if (reg_addr == ADDR_W'(REG_PEND))
      rd_mux = 32'(pend_q);
    else begin
      for (int w = 0; w < NWORDS; w++) begin
        if (reg_addr == ADDR_W'(REG_PRIO_BASE + w)) rd_mux = words[32*w +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N        = 28,
  parameter int unsigned NUM_TRAP = 4,
  parameter int unsigned ADDR_W   = 4,
  localparam int unsigned IDW     = $clog2(N)
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      src_pulse,
  input logic              cpu_ack,
  input logic              cpu_iret,
  input logic              cpu_di,
  input logic              cpu_trap,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq_req,
  input logic [IDW-1:0]    irq_id,
  input logic              gie,
  input logic [N-1:0]      pend
);
  assert_pulse_latched_R1: assert property (@(posedge clk) disable iff (rst)
    (|src_pulse) |=> ((pend & $past(src_pulse)) == $past(src_pulse)));

  assert_req_is_pending_R1: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> pend[irq_id]);

  assert_masked_only_traps_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !gie) |-> (32'(irq_id) < NUM_TRAP));

  assert_ack_drops_enable_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && irq_req) |=> !gie);

  assert_di_drops_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_di || cpu_trap) |=> !gie);

  assert_iret_sets_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_iret && !cpu_di && !cpu_trap && !(cpu_ack && irq_req) &&
     !(reg_we && reg_addr == '0 && !reg_wdata[0])) |=> gie);
endmodule

bind irq_ctrl irq_ctrl_chk #(.N(N), .NUM_TRAP(NUM_TRAP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .src_pulse(src_pulse), .cpu_ack(cpu_ack),
  .cpu_iret(cpu_iret), .cpu_di(cpu_di), .cpu_trap(cpu_trap),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_req(irq_req), .irq_id(irq_id), .gie(gie_q), .pend(pend_q)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  localparam int N  = 28;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] src_pulse = '0;
  logic        cpu_ack = 0, cpu_iret = 0, cpu_di = 0, cpu_trap = 0;
  logic        reg_we = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic [4:0]  irq_id;

  int n_chk = 0, n_fail = 0;

  irq_ctrl dut (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .cpu_ack(cpu_ack),
    .cpu_iret(cpu_iret), .cpu_di(cpu_di), .cpu_trap(cpu_trap),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_id(irq_id)
  );

  always #4 clk = ~clk;

  // Stimulus table: pulse pattern, expected request flag, expected index.
  localparam logic [N-1:0] V_PULSE [NV] = '{
    N'(1) << 4,                  // R2 lone tier-1 source
    (N'(1) << 4) | (N'(1) << 5), // R2 tier 2 beats tier 1
    (N'(1) << 5) | (N'(1) << 6), // R2 tier 3 beats tier 2
    (N'(1) << 6) | (N'(1) << 8), // R3 two tier-3 sources
    N'(1) << 7,                  // R5 disabled source
    (N'(1) << 9) | (N'(1) << 5), // R3 two tier-2 sources
    (N'(1) << 27) | (N'(1) << 4),// R3 two tier-1 sources
    (N'(1) << 2) | (N'(1) << 6), // R4 fault beats tier-3 peripheral
    N'(1) << 27,                 // R2 highest index alone
    (N'(1) << 7) | (N'(1) << 10) // R5 disabled skipped
  };
  localparam logic       V_REQ [NV] = '{1, 1, 1, 1, 0, 1, 1, 1, 1, 1};
  localparam logic [4:0] V_ID  [NV] = '{4, 5, 6, 6, 0, 5, 4, 2, 27, 10};

  function automatic logic [1:0] code_of(input int m);
    if (m == 3) return 2'b00;
    if (m == 2 || m == 4) return 2'b11;
    if (m == 1 || m == 5) return 2'b10;
    return 2'b01;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    src_pulse = p;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, w0, w1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R8 reset irq_req", 32'(irq_req), 0);
    rd(0, d); chk("R8 reset enable", d, 0);
    rd(1, d); chk("R1 reset pending", d, 0);

    w0 = '0; w1 = '0;
    for (int j = 0; j < 16; j++) w0[2*j +: 2] = code_of(j);
    for (int j = 0; j < 8; j++)  w1[2*j +: 2] = code_of(16 + j);
    wr(2, w0); wr(3, w1);
    rd(2, d); chk("R9 prio word0", d, w0);
    rd(3, d); chk("R9 prio word1", d, w1);
    rd(5, d); chk("R9 unmapped reads 0", d, 0);

    for (int v = 0; v < NV; v++) begin
      wr(1, 0); wr(0, 1);
      pulse(V_PULSE[v]);
      chk($sformatf("R2/R3 vec%0d irq_req", v), 32'(irq_req), 32'(V_REQ[v]));
      if (V_REQ[v]) chk($sformatf("R2/R3 vec%0d irq_id", v), 32'(irq_id), 32'(V_ID[v]));
    end

    // R4: enable clear masks peripherals but not fault sources
    wr(1, 0); wr(0, 0);
    pulse(N'(1) << 4);
    chk("R4 masked peripheral", 32'(irq_req), 0);
    rd(1, d); chk("R1 masked pulse still pending", d, 32'(1) << 4);
    pulse(N'(1) << 1);
    chk("R4 fault req while disabled", 32'(irq_req), 1);
    chk("R4 fault id while disabled", 32'(irq_id), 1);

    // R6: acknowledge clears the bit and the enable
    wr(1, 0); wr(0, 1);
    pulse(N'(1) << 6);
    chk("R6 presented id", 32'(irq_id), 6);
    cpu_ack = 1; @(negedge clk); cpu_ack = 0;
    chk("R6 req drops after ack", 32'(irq_req), 0);
    rd(1, d); chk("R6 ack clears pending", d, 0);
    rd(0, d); chk("R6 ack clears enable", d, 0);

    // R6: acknowledge without a request is ignored
    wr(0, 1);
    cpu_ack = 1; @(negedge clk); cpu_ack = 0;
    rd(0, d); chk("R6 stray ack keeps enable", d, 1);

    // R7: pulse and ack of the same source together
    pulse(N'(1) << 8);
    chk("R7 presented id", 32'(irq_id), 8);
    cpu_ack = 1; src_pulse = N'(1) << 8;
    @(negedge clk);
    cpu_ack = 0; src_pulse = '0;
    rd(1, d); chk("R7 pulse beats ack", d, 32'(1) << 8);
    rd(0, d); chk("R6 enable cleared by ack", d, 0);

    // R7: write 0 clears, write 1 keeps
    pulse((N'(1) << 4) | (N'(1) << 9));
    wr(1, ~(32'(1) << 8));
    rd(1, d); chk("R7 selective clear", d, (32'(1) << 4) | (32'(1) << 9));

    // R7: pulse during a clearing write wins
    reg_we = 1; reg_addr = 1; reg_wdata = 0; src_pulse = N'(1) << 9;
    @(negedge clk);
    reg_we = 0; src_pulse = '0;
    rd(1, d); chk("R7 pulse beats write", d, 32'(1) << 9);

    // R4/R8: enabling exposes the pending peripheral
    wr(0, 1);
    chk("R4 req after enable", 32'(irq_req), 1);
    chk("R4 id after enable", 32'(irq_id), 9);

    // R8: enable set and clear events
    cpu_di = 1; @(negedge clk); cpu_di = 0;
    rd(0, d); chk("R8 di clears", d, 0);
    cpu_iret = 1; @(negedge clk); cpu_iret = 0;
    rd(0, d); chk("R8 iret sets", d, 1);
    cpu_trap = 1; @(negedge clk); cpu_trap = 0;
    rd(0, d); chk("R8 trap clears", d, 0);
    cpu_iret = 1; cpu_di = 1; @(negedge clk); cpu_iret = 0; cpu_di = 0;
    rd(0, d); chk("R8 clear beats set", d, 0);
    wr(0, 1); rd(0, d); chk("R8 write 1 sets", d, 1);
    wr(0, 0); rd(0, d); chk("R8 write 0 clears", d, 0);

    finish_run();
  end
endmodule